// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small, fully associative record of loads that were hoisted above stores. Each entry holds the destination register of such a load, the byte address it read, and the width of the access. A store probes every entry in the same cycle. Any entry whose bytes overlap the bytes written by the store is dropped. Later, a check names a destination register. The table answers "hit" if the record for that register is still present, meaning the early load is still correct. It answers "recover" if the record is gone, meaning the load must be redone by recovery code.

There are three request ports: allocate, store probe and check. Each is a one-beat valid strobe with no ready. The table takes every request in the cycle it is offered and never applies back-pressure, so a source may present a beat on any port in any cycle. The check response is a single-cycle valid strobe. It carries exactly one of hit or recover and cannot be stalled, so the consumer must take it in that cycle. A global clear input empties the table.

Top module: `ldtrack_table`

## Requirements
- R1: After reset every entry is invalid, `chk_rsp_valid` is low, and a check of any register answers recover.
- R2: An allocation records the register, address and size code. The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A check in cycle t raises `chk_rsp_valid` in cycle t+1 only, with exactly one of `chk_hit` or `chk_recover` high. A check in any later cycle of a register recorded in an earlier cycle answers hit.
- R3: A check of a register that has no entry answers recover.
- R4: A store covers the bytes [addr, addr+size). It removes an entry only if that range shares at least one byte with the entry's range [addr, addr+size). A store that merely touches the range from either side leaves the entry.
- R5: One store removes every overlapping entry in the same cycle and leaves every non-overlapping entry.
- R6: When a store and a check arrive in the same cycle, the check sees the table after that store's removals.
- R7: Allocating a register that already has an entry overwrites that entry in place. Only the newest address governs later stores, and no second entry is made.
- R8: A new register takes the lowest-numbered free entry. When no entry is free, it replaces the entry under a round-robin pointer, which starts at entry 0 and advances by one, wrapping, only on such a replacement.
- R9: A check that hits leaves the entry valid.
- R10: Clear empties the table and returns the round-robin pointer to entry 0. It wins over an allocation in the same cycle, and a check in the same cycle answers recover.
- R11: A check in the same cycle as an allocation sees the table before that allocation. A store in the same cycle as an allocation does not remove the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Invalidate every entry |
| alc_valid | input | 1 | Allocation beat |
| alc_reg | input | 7 | Destination register of the hoisted load |
| alc_addr | input | 32 | Load byte address |
| alc_size | input | 2 | Load size code |
| st_valid | input | 1 | Store probe beat |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check beat |
| chk_reg | input | 7 | Register to validate |
| chk_rsp_valid | output | 1 | Check response strobe |
| chk_hit | output | 1 | Speculation still valid |
| chk_recover | output | 1 | Entry gone; redo the load |

## Verification
On every cycle, the assertions check the following:
- the response timing and the exclusive hit/recover pair;
- that at most one entry matches a checked register;
- that an overlapping store always kills the entry it hits, unless that entry is rewritten;
- that an allocation writes exactly one entry;
- that clear empties the table.

Other behaviour depends on the history of earlier operations, so only the directed scenarios can show it:
- the exact byte-range edges of the overlap test;
- the lowest-free choice and the round-robin victim order;
- overwrite in place;
- the ordering of same-cycle store, check, allocation and clear.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
  typedef logic [1:0] size_code_t;

  function automatic logic [3:0] size_bytes(input size_code_t c);
    return 4'd1 << c;
  endfunction
endpackage

// File: rtl/ldt_overlap.sv
module ldt_overlap #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]      a_base,
  input  ldt_pkg::size_code_t    a_size,
  input  logic [ADDR_W-1:0]      b_base,
  input  ldt_pkg::size_code_t    b_size,
  output logic                   hit
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = {1'b0, a_base};
    b_lo = {1'b0, b_base};
    a_hi = a_lo + EXT_W'(ldt_pkg::size_bytes(a_size));
    b_hi = b_lo + EXT_W'(ldt_pkg::size_bytes(b_size));
    hit  = (a_lo < b_hi) && (b_lo < a_hi);
  end
endmodule

// File: rtl/ldt_entry.sv
module ldt_entry #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_tag,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  ldt_pkg::size_code_t wr_size,
  input  logic                st_valid,
  input  logic [ADDR_W-1:0]   st_addr,
  input  ldt_pkg::size_code_t st_size,
  output logic                valid_o,
  output logic                live_o,
  output logic [REG_W-1:0]    tag_o
);
  logic                valid_q;
  logic [REG_W-1:0]    tag_q;
  logic [ADDR_W-1:0]   addr_q;
  ldt_pkg::size_code_t size_q;
  logic                overlap;

  ldt_overlap #(.ADDR_W(ADDR_W)) ovl_i (
    .a_base(addr_q), .a_size(size_q),
    .b_base(st_addr), .b_size(st_size),
    .hit(overlap)
  );

  // state after this cycle's store probe, before any allocation
  assign live_o  = valid_q && !(st_valid && overlap);
  assign valid_o = valid_q;
  assign tag_o   = tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      addr_q  <= '0;
      size_q  <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      tag_q   <= wr_tag;
      addr_q  <= wr_addr;
      size_q  <= wr_size;
    end else begin
      valid_q <= live_o;
    end
  end

  // R4
  store_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && st_valid && overlap && !wr_en) |=> !valid_q);
endmodule

// File: rtl/ldt_alloc_sel.sv
module ldt_alloc_sel #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               req,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] tag_hit,
  output logic [ENTRIES-1:0] wr_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0]   rr_q;
  logic [ENTRIES-1:0] free_v;
  logic               replace;
  logic               found;

  assign free_v = ~live;

  always_comb begin
    wr_o    = '0;
    found   = 1'b0;
    replace = 1'b0;
    if (req) begin
      if (|tag_hit) begin
        wr_o = tag_hit;
      end else if (|free_v) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (free_v[i] && !found) begin
            wr_o[i] = 1'b1;
            found   = 1'b1;
          end
        end
      end else begin
        wr_o[rr_q] = 1'b1;
        replace    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (clr)
      rr_q <= '0;
    else if (replace)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
  end

  // R8
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ($countones(wr_o) == 1));
  // R10
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (wr_o == '0));
endmodule

// File: rtl/ldtrack_table.sv
module ldtrack_table #(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                alc_valid,
  input  logic [REG_W-1:0]    alc_reg,
  input  logic [ADDR_W-1:0]   alc_addr,
  input  logic [1:0]          alc_size,
  input  logic                st_valid,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic [1:0]          st_size,
  input  logic                chk_valid,
  input  logic [REG_W-1:0]    chk_reg,
  output logic                chk_rsp_valid,
  output logic                chk_hit,
  output logic                chk_recover
);
  logic [ENTRIES-1:0] valid_v, live_v, alc_match, chk_match, wr_v;
  logic [REG_W-1:0]   tags [ENTRIES];
  logic               alc_req;
  logic               hit_now;

  assign alc_req = alc_valid && !clr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    ldt_entry #(.ADDR_W(ADDR_W), .REG_W(REG_W)) ent_i (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_en(wr_v[g]), .wr_tag(alc_reg), .wr_addr(alc_addr),
      .wr_size(alc_size),
      .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
      .valid_o(valid_v[g]), .live_o(live_v[g]), .tag_o(tags[g])
    );
    assign alc_match[g] = live_v[g] && (tags[g] == alc_reg);
    assign chk_match[g] = live_v[g] && (tags[g] == chk_reg);
  end

  ldt_alloc_sel #(.ENTRIES(ENTRIES)) sel_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .req(alc_req),
    .live(live_v), .tag_hit(alc_match), .wr_o(wr_v)
  );

  assign hit_now = (|chk_match) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_rsp_valid <= 1'b0;
      chk_hit       <= 1'b0;
      chk_recover   <= 1'b0;
    end else begin
      chk_rsp_valid <= chk_valid;
      chk_hit       <= chk_valid && hit_now;
      chk_recover   <= chk_valid && !hit_now;
    end
  end

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_rsp_valid);
  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_rsp_valid);
  // R2
  rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_rsp_valid |-> (chk_hit != chk_recover));
  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_match));
  // R10
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_v == '0));
  // R10
  clear_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && chk_valid) |=> chk_recover);
endmodule

// File: tb/ldtrack_table_tb_top.sv
module ldtrack_table_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, alc_valid = 0, st_valid = 0, chk_valid = 0;
  logic [6:0]  alc_reg = 0, chk_reg = 0;
  logic [31:0] alc_addr = 0, st_addr = 0;
  logic [1:0]  alc_size = 0, st_size = 0;
  logic chk_rsp_valid, chk_hit, chk_recover;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldtrack_table dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .alc_valid(alc_valid), .alc_reg(alc_reg), .alc_addr(alc_addr),
    .alc_size(alc_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .chk_rsp_valid(chk_rsp_valid), .chk_hit(chk_hit),
    .chk_recover(chk_recover)
  );

  task automatic idle_inputs();
    clr = 0; alc_valid = 0; st_valid = 0; chk_valid = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic set_alloc(input int r, input logic [31:0] a, input int s);
    alc_valid = 1; alc_reg = 7'(r); alc_addr = a; alc_size = 2'(s);
  endtask

  task automatic set_store(input logic [31:0] a, input int s);
    st_valid = 1; st_addr = a; st_size = 2'(s);
  endtask

  task automatic alloc(input int r, input logic [31:0] a, input int s);
    set_alloc(r, a, s); step();
  endtask

  task automatic store(input logic [31:0] a, input int s);
    set_store(a, s); step();
  endtask

  task automatic do_clear();
    clr = 1; step();
  endtask

  // issues a check (plus whatever else is already driven) and verifies the response
  task automatic probe(input int r, input bit exp_hit, input string req);
    logic [2:0] got, exp;
    chk_valid = 1; chk_reg = 7'(r);
    step();
    got = {chk_rsp_valid, chk_hit, chk_recover};
    exp = {1'b1, exp_hit, !exp_hit};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s reg %0d: got rsp/hit/rec=%b expected %b", req, r, got, exp);
    end
  endtask

  task automatic t_reset();
    checks++;
    if (chk_rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rsp_valid after reset: got %b expected 0", chk_rsp_valid);
    end
    probe(5, 0, "R1");
    probe(127, 0, "R1");
  endtask

  task automatic t_alloc_hit();
    alloc(1, 32'h100, 3);
    probe(1, 1, "R2");
    probe(1, 1, "R9");
    probe(2, 0, "R3");
    step();
    checks++;
    if (chk_rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 rsp_valid without check: got %b expected 0", chk_rsp_valid);
    end
  endtask

  task automatic t_overlap();
    do_clear();
    alloc(1, 32'h100, 2);
    store(32'h104, 0);
    probe(1, 1, "R4");
    store(32'h0FC, 2);
    probe(1, 1, "R4");
    store(32'h0FE, 1);
    probe(1, 1, "R4");
    store(32'h0FF, 1);
    probe(1, 0, "R4");
  endtask

  task automatic t_multi();
    do_clear();
    alloc(2, 32'h200, 3);
    alloc(3, 32'h204, 0);
    alloc(4, 32'h300, 3);
    store(32'h204, 2);
    probe(2, 0, "R5");
    probe(3, 0, "R5");
    probe(4, 1, "R5");
  endtask

  task automatic t_same_cycle();
    do_clear();
    alloc(5, 32'h400, 1);
    set_store(32'h401, 0);
    probe(5, 0, "R6");
    alloc(6, 32'h500, 0);
    set_store(32'h600, 0);
    probe(6, 1, "R6");
  endtask

  task automatic t_realloc();
    do_clear();
    alloc(7, 32'h700, 0);
    alloc(7, 32'h800, 0);
    store(32'h700, 0);
    probe(7, 1, "R7");
    store(32'h800, 0);
    probe(7, 0, "R7");
  endtask

  task automatic t_replace();
    do_clear();
    for (int i = 0; i < 8; i++) alloc(10 + i, 32'h1000 + 32'(16 * i), 0);
    alloc(20, 32'h2000, 0);
    probe(10, 0, "R8");
    probe(11, 1, "R8");
    probe(20, 1, "R8");
    alloc(21, 32'h2010, 0);
    probe(11, 0, "R8");
    probe(12, 1, "R8");
    store(32'h1030, 0);
    alloc(22, 32'h2020, 0);
    alloc(23, 32'h2030, 0);
    probe(12, 0, "R8");
    probe(22, 1, "R8");
    probe(23, 1, "R8");
    probe(14, 1, "R8");
    alloc(14, 32'h2040, 0);
    probe(15, 1, "R7");
    probe(16, 1, "R7");
    probe(17, 1, "R7");
    probe(14, 1, "R7");
  endtask

  task automatic t_clear();
    alloc(30, 32'h3000, 0);
    clr = 1; set_alloc(31, 32'h3100, 0); step();
    probe(31, 0, "R10");
    probe(30, 0, "R10");
    alloc(32, 32'h3200, 0);
    clr = 1;
    probe(32, 0, "R10");
    for (int i = 0; i < 8; i++) alloc(40 + i, 32'h4000 + 32'(16 * i), 0);
    do_clear();
    for (int i = 0; i < 8; i++) alloc(50 + i, 32'h5000 + 32'(16 * i), 0);
    alloc(60, 32'h6000, 0);
    probe(50, 0, "R10");
    probe(51, 1, "R10");
  endtask

  task automatic t_alloc_same();
    do_clear();
    set_alloc(70, 32'h7000, 0);
    probe(70, 0, "R11");
    probe(70, 1, "R11");
    set_alloc(71, 32'h900, 0);
    store(32'h900, 0);
    probe(71, 1, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alloc_hit();
    t_overlap();
    t_multi();
    t_same_cycle();
    t_realloc();
    t_replace();
    t_clear();
    t_alloc_same();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule